// File: doc/BRIEF.md
# Serially Concatenated Bit Encoder Chain with BPSK Output

This block is the coding part of a transmitter. It accepts one block of information bits at a time on a valid/ready bit stream and emits a stream of signed two-bit BPSK symbols, one symbol per coded bit. The chain has three stages:
- an outer half-rate recursive systematic convolutional encoder;
- a first bit interleaver followed by a rate-1 recursive accumulator as the inner code;
- a second bit interleaver followed by the BPSK mapper.

Both interleavers hold one whole block of coded bits. Each reads the block back in a permuted order of the form addr = (mul·i + ofs) mod N, where mul is coprime to N.

The outer code is chosen per block by a select pin. One choice is the constraint-length-3 code with octal generators 5/7, where 7 is the feedback polynomial. The other is a memory-1 code with octal generators 2/3. A block is normally INFO_LEN bits long. The default INFO_LEN is 1024, and the nominal 4096 is reached by the parameter. A block that the producer closes early with the end marker is padded with zero information bits up to INFO_LEN. Both encoder registers start every block from zero, and no termination bits are added. The coded block length is N = 2·INFO_LEN.

A single sequencer with five states runs the block through its phases.
- IDLE: waiting for a start marker.
- LOAD: taking bits and outer-encoding them into the first buffer.
- PAD: outer-encoding zero bits after an early end.
- MIX: reading the first buffer permuted, accumulating, and writing the second buffer linearly, one bit per cycle.
- EMIT: reading the second buffer permuted and presenting symbols.

The transitions are:
- IDLE→LOAD on a start bit that is not the last bit of the block.
- IDLE→PAD or LOAD→PAD on an end marker before the last bit position.
- IDLE→MIX, LOAD→MIX or PAD→MIX when the bit at position INFO_LEN−1 is encoded.
- MIX→EMIT after N bits.
- EMIT→IDLE when the last symbol is accepted.

Top module: `scc_bpsk_tx`

## Requirements
- R1: After reset, in_ready is 1 and sym_valid is 0.
- R2: Bits accepted while no block is open and without in_sop are discarded. They produce no symbols and do not alter the next block.
- R3: With code_sel=0, the outer code for info bit u_k uses state (s1,s2), which is zero at block start. It computes w=u_k^s1^s2 and parity=w^s2, then updates s2←s1 and s1←w.
- R4: With code_sel=1, the outer code uses w=u_k^s1 and parity=s1 (the value before update), then updates s1←w. code_sel is sampled on the first bit of a block and holds for the whole block.
- R5: The coded sequence has c[2k]=u_k (systematic bit) and c[2k+1]=parity of bit k.
- R6: The inner encoder takes its input bit j from c[(ILV1_MUL·j+ILV1_OFS) mod N].
- R7: The inner output is v_j = x_j ^ v_(j−1), with v_(−1)=0 at every block.
- R8: Symbol j carries v[(ILV2_MUL·j+ILV2_OFS) mod N]. Bit 0 is sent as +1 (2'b01) and bit 1 as −1 (2'b11).
- R9: Each block yields exactly N symbols, and sym_last is 1 only with symbol N−1. A block closes after INFO_LEN bits whatever in_eop shows. in_sop inside an open block has no effect.
- R10: in_ready is 0 from the acceptance of the last info bit until the last symbol is accepted. It returns to 1 the cycle after that.
- R11: While sym_valid is 1 and sym_ready is 0, sym_data and sym_last hold their values.
- R12: A block ended by in_eop after L<INFO_LEN bits is encoded as if bits L..INFO_LEN−1 were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_sel | input | 1 | Outer code choice (0: 5/7, 1: 2/3), sampled on first bit |
| in_valid | input | 1 | Info bit valid |
| in_ready | output | 1 | Block accepts an info bit |
| in_bit | input | 1 | Info bit |
| in_sop | input | 1 | First bit of a block |
| in_eop | input | 1 | Last bit of a block |
| sym_valid | output | 1 | Symbol valid |
| sym_ready | input | 1 | Consumer accepts symbol |
| sym_data | output | 2 | Signed BPSK symbol, +1 or −1 |
| sym_last | output | 1 | Final symbol of the block |

## Verification
The bench sweeps every 8-bit information pattern under both outer codes. It uses a 16-bit coded block and odd interleaver multipliers, so a wrong tap, a swapped systematic/parity order, a wrong wrap in the address step or an accumulator not cleared between blocks each corrupts specific symbols. A design that keeps encoder state across blocks shows up because the sweep runs blocks back to back. Stray bits without a start marker, misplaced start and end markers and short blocks closed by the end marker are mixed in. A design that opened a block on stray bits, or closed one on a stray end marker, would shift or truncate the output. Stalling the consumer on a fixed rhythm exposes symbols that change or advance without a handshake, and exposes input that is accepted while the buffers are still draining.

// File: rtl/scc_tx_pkg.sv
package scc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_PAD  = 3'd2,
        ST_MIX  = 3'd3,
        ST_EMIT = 3'd4
    } tx_state_e;

    typedef enum logic {
        CODE_57 = 1'b0,
        CODE_23 = 1'b1
    } outer_code_e;

    localparam logic signed [1:0] SYM_PLUS  = 2'sb01;
    localparam logic signed [1:0] SYM_MINUS = 2'sb11;

endpackage

// File: rtl/outer_rsc_enc.sv
module outer_rsc_enc
    import scc_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fresh,
    input  logic        adv,
    input  outer_code_e code,
    input  logic        in_u,
    output logic        sys_bit,
    output logic        par_bit
);

    logic s1_q, s2_q;
    logic s1, s2;
    logic w;

    // a fresh block starts from the zero state without a separate clear cycle
    assign s1 = fresh ? 1'b0 : s1_q;
    assign s2 = fresh ? 1'b0 : s2_q;

    always_comb begin
        unique case (code)
            CODE_57: begin
                w       = in_u ^ s1 ^ s2;
                par_bit = w ^ s2;
            end
            CODE_23: begin
                w       = in_u ^ s1;
                par_bit = s1;
            end
            default: begin
                w       = 1'b0;
                par_bit = 1'b0;
            end
        endcase
    end

    assign sys_bit = in_u;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else if (adv) begin
            s1_q <= w;
            s2_q <= (code == CODE_57) ? s1 : 1'b0;
        end
    end

endmodule

// File: rtl/inner_accum.sv
module inner_accum (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    input  logic x_bit,
    output logic v_bit
);

    logic acc_q;

    assign v_bit = x_bit ^ acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
        end else if (clear) begin
            acc_q <= 1'b0;
        end else if (adv) begin
            acc_q <= v_bit;
        end
    end

endmodule

// File: rtl/perm_addr_gen.sv
module perm_addr_gen #(
    parameter int unsigned N   = 16,
    parameter int unsigned MUL = 5,
    parameter int unsigned OFS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 step,
    output logic [$clog2(N)-1:0] addr
);

    localparam int unsigned AW = $clog2(N);
    localparam logic [AW:0] STEP_W = (AW+1)'(MUL % N);
    localparam logic [AW:0] LIM_W  = (AW+1)'(N);
    localparam logic [AW-1:0] START_W = AW'(OFS % N);

    logic [AW:0] sum;
    logic [AW:0] wrapped;

    // (MUL*i + OFS) mod N built by repeated addition with one conditional subtract
    assign sum     = {1'b0, addr} + STEP_W;
    assign wrapped = (sum >= LIM_W) ? (sum - LIM_W) : sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= START_W;
        end else if (restart) begin
            addr <= START_W;
        end else if (step) begin
            addr <= wrapped[AW-1:0];
        end
    end

endmodule

// File: rtl/bit_block_buf.sv
module bit_block_buf #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LANES = 1
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wbase,
    input  logic [LANES-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic                     rdata
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic [DEPTH-1:0] mem;

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                mem[wbase + AW'(l)] <= wdata[l];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/scc_bpsk_tx.sv
module scc_bpsk_tx
    import scc_tx_pkg::*;
#(
    parameter int unsigned INFO_LEN = 1024,
    parameter int unsigned ILV1_MUL = 29,
    parameter int unsigned ILV1_OFS = 7,
    parameter int unsigned ILV2_MUL = 45,
    parameter int unsigned ILV2_OFS = 101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_bit,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              sym_valid,
    input  logic              sym_ready,
    output logic signed [1:0] sym_data,
    output logic              sym_last
);

    localparam int unsigned CODED_LEN = 2 * INFO_LEN;
    localparam int unsigned CAW = $clog2(CODED_LEN);
    localparam int unsigned IAW = (INFO_LEN > 1) ? $clog2(INFO_LEN) : 1;
    localparam logic [IAW-1:0] LAST_INFO  = IAW'(INFO_LEN - 1);
    localparam logic [CAW-1:0] LAST_CODED = CAW'(CODED_LEN - 1);

    tx_state_e   state_q, state_d;
    outer_code_e code_q, code_now;

    logic           take, first_take, load_take, pad_step, enc_adv;
    logic           enc_u, last_info, early_end;
    logic [IAW-1:0] info_idx_q, cur_idx;
    logic           sys_bit, par_bit;
    logic [CAW-1:0] p1_addr, p2_addr;
    logic [CAW-1:0] mix_idx_q, emit_idx_q;
    logic           mix_step, mix_done, emit_take, emit_done;
    logic           c_bit, v_bit, s_bit;

    // ---------------- handshakes and phase strobes ----------------
    assign take       = in_valid && in_ready;
    assign first_take = take && (state_q == ST_IDLE) && in_sop;
    assign load_take  = take && (state_q == ST_LOAD);
    assign pad_step   = (state_q == ST_PAD);
    assign enc_adv    = first_take || load_take || pad_step;
    assign enc_u      = pad_step ? 1'b0 : in_bit;
    assign cur_idx    = first_take ? '0 : info_idx_q;
    assign last_info  = enc_adv && (cur_idx == LAST_INFO);
    assign early_end  = (first_take || load_take) && in_eop && !last_info;
    assign code_now   = first_take ? outer_code_e'(code_sel) : code_q;

    assign mix_step   = (state_q == ST_MIX);
    assign mix_done   = mix_step && (mix_idx_q == LAST_CODED);
    assign emit_take  = sym_valid && sym_ready;
    assign emit_done  = emit_take && (emit_idx_q == LAST_CODED);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (first_take) begin
                    if (last_info)      state_d = ST_MIX;
                    else if (early_end) state_d = ST_PAD;
                    else                state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (last_info)      state_d = ST_MIX;
                else if (early_end) state_d = ST_PAD;
            end
            ST_PAD: begin
                if (last_info) state_d = ST_MIX;
            end
            ST_MIX: begin
                if (mix_done) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (emit_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        sym_valid = 1'b0;
        sym_last  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LOAD: in_ready = 1'b1;
            ST_EMIT: begin
                sym_valid = 1'b1;
                sym_last  = (emit_idx_q == LAST_CODED);
            end
            default: ;
        endcase
        sym_data = s_bit ? SYM_MINUS : SYM_PLUS;
    end

    // ---------------- counters ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_idx_q <= '0;
            code_q     <= CODE_57;
            mix_idx_q  <= '0;
            emit_idx_q <= '0;
        end else begin
            if (first_take) code_q <= outer_code_e'(code_sel);
            if (enc_adv)    info_idx_q <= last_info ? '0 : cur_idx + 1'b1;
            if (last_info)     mix_idx_q <= '0;
            else if (mix_step) mix_idx_q <= mix_idx_q + 1'b1;
            if (mix_done)       emit_idx_q <= '0;
            else if (emit_take) emit_idx_q <= emit_idx_q + 1'b1;
        end
    end

    // ---------------- stage 1: outer code into first buffer ----------------
    outer_rsc_enc u_outer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fresh   (first_take),
        .adv     (enc_adv),
        .code    (code_now),
        .in_u    (enc_u),
        .sys_bit (sys_bit),
        .par_bit (par_bit)
    );

    bit_block_buf #(.DEPTH(CODED_LEN), .LANES(2)) u_buf1 (
        .clk   (clk),
        .we    (enc_adv),
        .wbase (CAW'({cur_idx, 1'b0})),
        .wdata ({par_bit, sys_bit}),
        .raddr (p1_addr),
        .rdata (c_bit)
    );

    // ---------------- stage 2: first permutation and accumulator ----------------
    perm_addr_gen #(.N(CODED_LEN), .MUL(ILV1_MUL), .OFS(ILV1_OFS)) u_perm1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (last_info),
        .step    (mix_step),
        .addr    (p1_addr)
    );

    inner_accum u_inner (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (last_info),
        .adv   (mix_step),
        .x_bit (c_bit),
        .v_bit (v_bit)
    );

    bit_block_buf #(.DEPTH(CODED_LEN), .LANES(1)) u_buf2 (
        .clk   (clk),
        .we    (mix_step),
        .wbase (mix_idx_q),
        .wdata (v_bit),
        .raddr (p2_addr),
        .rdata (s_bit)
    );

    // ---------------- stage 3: second permutation to the mapper ----------------
    perm_addr_gen #(.N(CODED_LEN), .MUL(ILV2_MUL), .OFS(ILV2_OFS)) u_perm2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (mix_done),
        .step    (emit_take),
        .addr    (p2_addr)
    );

endmodule

// File: rtl/scc_bpsk_tx_chk.sv
module scc_bpsk_tx_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              sym_valid,
    input logic              sym_ready,
    input logic signed [1:0] sym_data,
    input logic              sym_last
);

    // R10: input side and output side never open together
    assert_exclusive_sides_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> !in_ready);

    // R10: after the final symbol is taken the block reopens
    assert_reopen_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready && sym_last) |=> (in_ready && !sym_valid));

    // R11: a stalled symbol holds
    assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data) && $stable(sym_last)));

    // R8: only the two BPSK levels appear
    assert_legal_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_data == 2'sb01 || sym_data == 2'sb11));

    // R9: the block marker only comes with a valid symbol
    assert_last_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sym_last |-> sym_valid);

endmodule

bind scc_bpsk_tx scc_bpsk_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .sym_data  (sym_data),
    .sym_last  (sym_last)
);

// File: tb/tb_scc_bpsk_tx.sv
`timescale 1ns/1ps
module tb_scc_bpsk_tx;

    localparam int K  = 8;
    localparam int N  = 2 * K;
    localparam int A1 = 5;
    localparam int B1 = 3;
    localparam int A2 = 7;
    localparam int B2 = 11;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic code_sel = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_sop = 1'b0;
    logic in_eop = 1'b0;
    logic sym_ready = 1'b0;
    logic in_ready, sym_valid, sym_last;
    logic signed [1:0] sym_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int stall_seq = 0;

    always #10 clk = ~clk;

    scc_bpsk_tx #(
        .INFO_LEN (K),
        .ILV1_MUL (A1),
        .ILV1_OFS (B1),
        .ILV2_MUL (A2),
        .ILV2_OFS (B2)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_sel  (code_sel),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .sym_valid (sym_valid),
        .sym_ready (sym_ready),
        .sym_data  (sym_data),
        .sym_last  (sym_last)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD_LIMIT) begin
            n_fails = n_fails + 1;
            $display("FAIL R10 watchdog: actual %0d cycles, expected below %0d", cycles, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3 R4 R5: outer code reference
    function automatic logic [N-1:0] outer_ref(input logic [K-1:0] info, input bit code);
        logic [N-1:0] c;
        logic s1, s2, w, p;
        s1 = 1'b0; s2 = 1'b0; c = '0;
        for (int k = 0; k < K; k++) begin
            if (code == 1'b0) begin
                w = info[k] ^ s1 ^ s2; p = w ^ s2; s2 = s1; s1 = w;
            end else begin
                w = info[k] ^ s1; p = s1; s1 = w; s2 = 1'b0;
            end
            c[2*k]   = info[k];
            c[2*k+1] = p;
        end
        return c;
    endfunction

    // R6 R7 R8: interleave, accumulate, interleave
    function automatic logic [N-1:0] chain_ref(input logic [K-1:0] info, input bit code);
        logic [N-1:0] c, v, s;
        logic acc;
        c = outer_ref(info, code);
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            acc = acc ^ c[(A1 * j + B1) % N];
            v[j] = acc;
        end
        for (int j = 0; j < N; j++) s[j] = v[(A2 * j + B2) % N];
        return s;
    endfunction

    task automatic send_bit(input logic b, input logic sop, input logic eop);
        @(negedge clk);
        in_valid = 1'b1; in_bit = b; in_sop = sop; in_eop = eop;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic recv_block(input logic [N-1:0] exp_bits, input string tag);
        int j;
        bit have_prev;
        logic signed [1:0] prev_d;
        logic prev_l;
        j = 0; have_prev = 0; prev_d = '0; prev_l = 1'b0;
        while (j < N) begin
            @(negedge clk);
            if (sym_valid && have_prev) begin
                chk(sym_data == prev_d, "R11", "stalled data", sym_data, prev_d);
                chk(sym_last == prev_l, "R11", "stalled last", sym_last, prev_l);
            end
            chk(in_ready == 1'b0, "R10", "in_ready while busy", in_ready, 0);
            stall_seq++;
            sym_ready = ((stall_seq % 3) != 1);
            if (sym_valid) begin
                if (sym_ready) begin
                    chk(sym_data == (exp_bits[j] ? 2'sb11 : 2'sb01), tag,
                        $sformatf("symbol %0d", j), sym_data, exp_bits[j] ? -1 : 1);
                    chk(sym_last == (j == N - 1), "R9", $sformatf("last at %0d", j),
                        sym_last, (j == N - 1));
                    j++;
                    have_prev = 0;
                end else begin
                    have_prev = 1; prev_d = sym_data; prev_l = sym_last;
                end
            end
        end
        @(negedge clk);
        sym_ready = 1'b0;
        chk(in_ready == 1'b1, "R10", "in_ready after block", in_ready, 1);
        chk(sym_valid == 1'b0, "R9", "no extra symbol", sym_valid, 0);
    endtask

    initial begin
        logic [K-1:0] info;
        string tag;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        chk(sym_valid == 1'b0, "R1", "sym_valid in reset", sym_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(sym_valid == 1'b0, "R1", "sym_valid after reset", sym_valid, 0);

        // full blocks: every pattern under both outer codes
        for (int code = 0; code < 2; code++) begin
            for (int pat = 0; pat < (1 << K); pat++) begin
                info = K'(pat);
                if (pat % 5 == 0) begin
                    // R2: stray bits without a start marker
                    send_bit(1'b1, 1'b0, 1'b0);
                    send_bit(1'b0, 1'b0, 1'b1);
                    @(negedge clk);
                    chk(sym_valid == 1'b0, "R2", "stray bits made output", sym_valid, 0);
                    chk(in_ready == 1'b1, "R2", "stray bits opened block", in_ready, 1);
                end
                code_sel = code[0];
                for (int k = 0; k < K; k++) begin
                    send_bit(info[k], (k == 0) || ((pat % 7 == 3) && k == 4),
                             (k == K - 1) && (pat % 11 != 0));
                    if (k == 0) code_sel = ~code[0]; // R4: sampled on first bit only
                end
                code_sel = 1'b0;
                tag = (code == 0) ? "R3 R5 R6 R7 R8" : "R4 R5 R6 R7 R8";
                if (pat % 5 == 0) tag = {tag, " R2"};
                recv_block(chain_ref(info, code[0]), tag);
            end
        end

        // R12: short blocks closed by the end marker
        for (int code = 0; code < 2; code++) begin
            for (int len = 1; len < K; len++) begin
                info = K'((8'hB5 ^ (len * 37)) & ((1 << len) - 1));
                code_sel = code[0];
                for (int k = 0; k < len; k++)
                    send_bit(info[k], k == 0, k == len - 1);
                recv_block(chain_ref(info, code[0]), "R12");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule